// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides whether a received CAN frame header is kept. Each incoming identifier, with its IDE and RTR bits, is compared in parallel against a bank of programmable filters. A filter can be switched on or off. It works either as an identifier with a bit mask or as a list of exact identifiers. It operates either as one 32-bit filter or as two 16-bit filters. When a frame is kept, the block reports which of two receive queues it goes to, along with an 8-bit match index that numbers the individual filter elements across the whole bank.

Configuration is written through a small write port. It takes effect only while the configuration-mode input is high. While that input is high, incoming frames are not filtered at all. The verdict for a frame appears on the registered outputs one clock after the frame is presented. Frame storage and bit timing are handled elsewhere.

Top module: `can_id_filter_bank`

## Requirements
- R1: After reset every filter is inactive, in 16-bit mask form, routed to queue 0, with both registers zero, and all outputs are 0; a frame presented before any configuration is rejected.
- R2: Configuration writes (`cfg_we_i`) take effect only while `cfg_mode_i` is 1. `cfg_sel_i` chooses the target: 0 activation word, 1 mode word (bit f = 1 makes filter f a list), 2 width word (bit f = 1 makes filter f one 32-bit filter), 3 queue word, 4 register A of filter `cfg_idx_i`, 5 register B of filter `cfg_idx_i`.
- R3: While `cfg_mode_i` is 1, presented frames are not filtered and `res_valid_o` stays 0.
- R4: A frame presented with `frm_valid_i` = 1 in normal mode yields `res_valid_o` = 1 on the following cycle only.
- R5: A 32-bit mask filter compares the word {sid[10:0], eid[17:0], ide, rtr, 0} with register A on every bit [31:1] where register B holds a 1.
- R6: A 32-bit list filter matches when bits [31:1] of that word equal register A or register B.
- R7: A 16-bit filter compares the half-word {sid[10:0], rtr, ide, eid[17:15]}; in mask mode each register holds the identifier in [15:0] and the mask in [31:16].
- R8: A 16-bit list filter holds four exact identifiers, in element order A[15:0], A[31:16], B[15:0], B[31:16].
- R9: A filter whose activation bit is 0 never matches.
- R10: When several filters match, the lowest-numbered one wins; inside a filter, the lowest element wins.
- R11: The match index is the winner's element offset plus the element counts of all lower-numbered filters, whether or not they are active: 1 for a 32-bit mask filter, 2 for a 32-bit list or 16-bit mask filter, 4 for a 16-bit list filter.
- R12: `queue_o` equals the queue-word bit of the winning filter.
- R13: A frame that matches no active filter gives `accept_o` = 0, `queue_o` = 0 and `match_idx_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 1 | Configuration mode: writes allowed, filtering halted |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration target select |
| cfg_idx_i | input | 5 | Filter number for register writes |
| cfg_wdata_i | input | 32 | Configuration write data |
| frm_valid_i | input | 1 | Frame header present |
| frm_sid_i | input | 11 | Standard identifier |
| frm_eid_i | input | 18 | Extended identifier low bits |
| frm_ide_i | input | 1 | Extended-format flag |
| frm_rtr_i | input | 1 | Remote-request flag |
| res_valid_o | output | 1 | Verdict present |
| accept_o | output | 1 | Frame accepted |
| queue_o | output | 1 | Target receive queue |
| match_idx_o | output | 8 | Filter element match index |

## Verification
The bench builds the block with its defaults: 28 filters and an 8-bit index. With those values, the top filter (number 27) sits at a computed index base of 57, behind a mix of 32-bit, list and default 16-bit filters. This exercises the full prefix sum across the bank, rather than a short one. All four filter variants are configured at once, so overlapping matches test priority between filters and priority between elements inside one filter.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int SID_W  = 11;
  localparam int EID_W  = 18;

  typedef enum logic [2:0] {
    CFG_ACT   = 3'd0,
    CFG_MODE  = 3'd1,
    CFG_WIDTH = 3'd2,
    CFG_QUEUE = 3'd3,
    CFG_REG_A = 3'd4,
    CFG_REG_B = 3'd5
  } cfg_sel_e;

  // element count per filter variant
  function automatic logic [2:0] elem_count(input logic list, input logic wide);
    case ({wide, list})
      2'b10:   return 3'd1;
      2'b11:   return 3'd2;
      2'b00:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/can_filt_cfg.sv
module can_filt_cfg
  import can_filt_pkg::*;
#(
  parameter int NF = 28,
  localparam int FW = $clog2(NF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mode_i,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [FW-1:0]     idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [NF-1:0]     act_o,
  output logic [NF-1:0]     list_o,
  output logic [NF-1:0]     wide_o,
  output logic [NF-1:0]     queue_o,
  output logic [WORD_W-1:0] reg_a_o [NF],
  output logic [WORD_W-1:0] reg_b_o [NF]
);
  logic wr;
  assign wr = cfg_mode_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o   <= '0;
      list_o  <= '0;
      wide_o  <= '0;
      queue_o <= '0;
    end else if (wr) begin
      case (sel_i)
        CFG_ACT:   act_o   <= wdata_i[NF-1:0];
        CFG_MODE:  list_o  <= wdata_i[NF-1:0];
        CFG_WIDTH: wide_o  <= wdata_i[NF-1:0];
        CFG_QUEUE: queue_o <= wdata_i[NF-1:0];
        default: ;
      endcase
    end
  end

  for (genvar f = 0; f < NF; f++) begin : g_regs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_a_o[f] <= '0;
        reg_b_o[f] <= '0;
      end else if (wr && idx_i == FW'(f)) begin
        if (sel_i == CFG_REG_A) reg_a_o[f] <= wdata_i;
        if (sel_i == CFG_REG_B) reg_b_o[f] <= wdata_i;
      end
    end
  end

  // R2: outside configuration mode the bank words are frozen
  a_r2_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_i |=> $stable(act_o) && $stable(list_o) && $stable(wide_o) && $stable(queue_o));
endmodule

// File: rtl/can_filt_elem.sv
module can_filt_elem
  import can_filt_pkg::*;
(
  input  logic [WORD_W-1:0] key32_i,
  input  logic [HALF_W-1:0] key16_i,
  input  logic [WORD_W-1:0] reg_a_i,
  input  logic [WORD_W-1:0] reg_b_i,
  input  logic              list_i,
  input  logic              wide_i,
  output logic              hit_o,
  output logic [1:0]        off_o
);
  logic [3:0]        e;
  logic [WORD_W-1:0] diff32;

  assign diff32 = (key32_i ^ reg_a_i) & reg_b_i;

  always_comb begin
    e = '0;
    if (wide_i) begin
      if (list_i) begin
        e[0] = key32_i[WORD_W-1:1] == reg_a_i[WORD_W-1:1];
        e[1] = key32_i[WORD_W-1:1] == reg_b_i[WORD_W-1:1];
      end else begin
        e[0] = diff32[WORD_W-1:1] == '0;
      end
    end else if (list_i) begin
      e[0] = key16_i == reg_a_i[HALF_W-1:0];
      e[1] = key16_i == reg_a_i[WORD_W-1:HALF_W];
      e[2] = key16_i == reg_b_i[HALF_W-1:0];
      e[3] = key16_i == reg_b_i[WORD_W-1:HALF_W];
    end else begin
      e[0] = ((key16_i ^ reg_a_i[HALF_W-1:0]) & reg_a_i[WORD_W-1:HALF_W]) == '0;
      e[1] = ((key16_i ^ reg_b_i[HALF_W-1:0]) & reg_b_i[WORD_W-1:HALF_W]) == '0;
    end
  end

  assign hit_o = |e;

  always_comb begin
    off_o = 2'd0;
    for (int i = 3; i >= 0; i--) if (e[i]) off_o = 2'(i);
  end
endmodule

// File: rtl/can_filt_sel.sv
module can_filt_sel
  import can_filt_pkg::*;
#(
  parameter int NF    = 28,
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NF-1:0]    hit_i,
  input  logic [NF-1:0]    act_i,
  input  logic [NF-1:0]    queue_i,
  input  logic [NF-1:0]    list_i,
  input  logic [NF-1:0]    wide_i,
  input  logic [1:0]       off_i [NF],
  output logic             any_o,
  output logic             queue_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [NF-1:0]    win_oh;
  logic [IDX_W-1:0] base, total;

  always_comb begin
    base    = '0;
    any_o   = 1'b0;
    queue_o = 1'b0;
    idx_o   = '0;
    win_oh  = '0;
    for (int f = 0; f < NF; f++) begin
      if (!any_o && hit_i[f] && act_i[f]) begin
        any_o     = 1'b1;
        win_oh[f] = 1'b1;
        queue_o   = queue_i[f];
        idx_o     = base + IDX_W'(off_i[f]);
      end
      base = base + IDX_W'(elem_count(list_i[f], wide_i[f]));
    end
    total = base;
  end

  // R10: at most one filter wins
  a_r10_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_oh) && (any_o == (win_oh != '0)));
  // R11: index stays inside the element range of the bank
  a_r11_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> idx_o < total);
endmodule

// File: rtl/can_id_filter_bank.sv
module can_id_filter_bank
  import can_filt_pkg::*;
#(
  parameter int NF    = 28,
  parameter int IDX_W = 8,
  localparam int FW   = $clog2(NF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_mode_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [FW-1:0]     cfg_idx_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic              frm_valid_i,
  input  logic [SID_W-1:0]  frm_sid_i,
  input  logic [EID_W-1:0]  frm_eid_i,
  input  logic              frm_ide_i,
  input  logic              frm_rtr_i,
  output logic              res_valid_o,
  output logic              accept_o,
  output logic              queue_o,
  output logic [IDX_W-1:0]  match_idx_o
);
  logic [NF-1:0]     act, list, wide, qsel, hit;
  logic [WORD_W-1:0] reg_a [NF];
  logic [WORD_W-1:0] reg_b [NF];
  logic [1:0]        off   [NF];
  logic [WORD_W-1:0] key32;
  logic [HALF_W-1:0] key16;
  logic              any, win_q;
  logic [IDX_W-1:0]  win_idx;

  assign key32 = {frm_sid_i, frm_eid_i, frm_ide_i, frm_rtr_i, 1'b0};
  assign key16 = {frm_sid_i, frm_rtr_i, frm_ide_i, frm_eid_i[EID_W-1 -: 3]};

  can_filt_cfg #(.NF(NF)) u_cfg (
    .clk_i, .rst_ni, .cfg_mode_i,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .idx_i(cfg_idx_i), .wdata_i(cfg_wdata_i),
    .act_o(act), .list_o(list), .wide_o(wide), .queue_o(qsel),
    .reg_a_o(reg_a), .reg_b_o(reg_b)
  );

  for (genvar f = 0; f < NF; f++) begin : g_elem
    can_filt_elem u_elem (
      .key32_i(key32), .key16_i(key16),
      .reg_a_i(reg_a[f]), .reg_b_i(reg_b[f]),
      .list_i(list[f]), .wide_i(wide[f]),
      .hit_o(hit[f]), .off_o(off[f])
    );
  end

  can_filt_sel #(.NF(NF), .IDX_W(IDX_W)) u_sel (
    .clk_i, .rst_ni,
    .hit_i(hit), .act_i(act), .queue_i(qsel), .list_i(list), .wide_i(wide),
    .off_i(off), .any_o(any), .queue_o(win_q), .idx_o(win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      accept_o    <= 1'b0;
      queue_o     <= 1'b0;
      match_idx_o <= '0;
    end else begin
      res_valid_o <= frm_valid_i && !cfg_mode_i;
      accept_o    <= frm_valid_i && !cfg_mode_i && any;
      queue_o     <= frm_valid_i && !cfg_mode_i && any && win_q;
      match_idx_o <= (frm_valid_i && !cfg_mode_i && any) ? win_idx : '0;
    end
  end

  a_r4_verdict_follows_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(frm_valid_i && !cfg_mode_i));
  a_r3_quiet_in_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mode_i |=> !res_valid_o);
  a_r13_reject_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> (match_idx_o == '0) && !queue_o);
  a_r1_accept_has_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> res_valid_o);
endmodule

// File: tb/can_id_filter_bank_tb.sv
`timescale 1ns/1ps
module can_id_filter_bank_tb;
  localparam int NF = 28;
  localparam int IDX_W = 8;
  localparam int VW = 11 + 18 + 1 + 1 + 1 + 1 + 8;
  localparam int NV = 14;

  // {sid, eid, ide, rtr, exp_accept, exp_queue, exp_idx}
  localparam logic [VW-1:0] VEC [NV] = '{
    {11'h123, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0},   // R5 F0 mask32
    {11'h123, 18'h12345, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0},   // R5 eid masked off
    {11'h123, 18'h00000, 1'b0, 1'b1, 1'b1, 1'b1, 8'd57},  // R5 rtr compared, F27
    {11'h7FF, 18'h3FFFF, 1'b1, 1'b0, 1'b1, 1'b1, 8'd5},   // R6 F2 A
    {11'h001, 18'h00005, 1'b1, 1'b1, 1'b1, 1'b1, 8'd6},   // R6 F2 B
    {11'h2AB, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'd7},   // R7 F3 A
    {11'h2AB, 18'h00000, 1'b0, 1'b1, 1'b1, 1'b1, 8'd57},  // R7 rtr masked in
    {11'h055, 18'h38000, 1'b0, 1'b1, 1'b1, 1'b0, 8'd8},   // R7 F3 B, eid hi masked
    {11'h010, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b1, 8'd9},   // R8 F4 elem 0
    {11'h011, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b1, 8'd10},  // R8 elem 1
    {11'h012, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b1, 8'd11},  // R8 elem 2
    {11'h200, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'd7},   // R10 F3 beats F4
    {11'h050, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b1, 8'd57},  // R9 F1 inactive
    {11'h010, 18'h08000, 1'b0, 1'b0, 1'b1, 1'b1, 8'd57}   // R8 eid[15] compared
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_mode_i = 1'b0, cfg_we_i = 1'b0;
  logic [2:0] cfg_sel_i = '0;
  logic [4:0] cfg_idx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic frm_valid_i = 1'b0, frm_ide_i = 1'b0, frm_rtr_i = 1'b0;
  logic [10:0] frm_sid_i = '0;
  logic [17:0] frm_eid_i = '0;
  logic res_valid_o, accept_o, queue_o;
  logic [IDX_W-1:0] match_idx_o;
  int checks = 0, fails = 0;

  always #10 clk_i = ~clk_i;

  can_id_filter_bank #(.NF(NF), .IDX_W(IDX_W)) u_dut (.*);

  task automatic wr(input logic [2:0] sel, input int idx, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_idx_i = 5'(idx); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic send(input logic [10:0] sid, input logic [17:0] eid,
                      input logic ide, input logic rtr);
    @(negedge clk_i);
    frm_valid_i = 1'b1; frm_sid_i = sid; frm_eid_i = eid; frm_ide_i = ide; frm_rtr_i = rtr;
    @(negedge clk_i);
    frm_valid_i = 1'b0;
  endtask

  task automatic check(input string req, input logic v, input logic a,
                       input logic q, input logic [7:0] idx);
    checks++;
    if ({res_valid_o, accept_o, queue_o, match_idx_o} !== {v, a, q, idx}) begin
      fails++;
      $display("FAIL %s: got v=%0b a=%0b q=%0b idx=%0d, expected v=%0b a=%0b q=%0b idx=%0d",
               req, res_valid_o, accept_o, queue_o, match_idx_o, v, a, q, idx);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset outputs", 1'b0, 1'b0, 1'b0, 8'd0);
    rst_ni = 1'b1;
    send(11'h123, 18'h0, 1'b0, 1'b0);
    check("R1 unconfigured rejects", 1'b1, 1'b0, 1'b0, 8'd0);
    @(negedge clk_i);
    check("R4 verdict lasts one cycle", 1'b0, 1'b0, 1'b0, 8'd0);

    cfg_mode_i = 1'b1;
    wr(3'd0, 0, 32'h0800_001D);   // active: F0,F2,F3,F4,F27
    wr(3'd1, 0, 32'h0000_0016);   // list:   F1,F2,F4
    wr(3'd2, 0, 32'h0800_0005);   // 32-bit: F0,F2,F27
    wr(3'd3, 0, 32'h0800_0014);   // queue1: F2,F4,F27
    wr(3'd4, 0, 32'h2460_0000); wr(3'd5, 0, 32'hFFE0_0006);
    wr(3'd4, 1, 32'h0A00_0A00); wr(3'd5, 1, 32'h0A00_0A00);
    wr(3'd4, 2, 32'hFFFF_FFFC); wr(3'd5, 2, 32'h0020_002E);
    wr(3'd4, 3, 32'hE018_4000); wr(3'd5, 3, 32'hFFF8_0AB0);
    wr(3'd4, 4, 32'h0220_0200); wr(3'd5, 4, 32'h4000_0240);
    send(11'h123, 18'h0, 1'b0, 1'b0);
    check("R3 no verdict in config mode", 1'b0, 1'b0, 1'b0, 8'd0);
    cfg_mode_i = 1'b0;

    // table: R11 indices, R12 queues
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      send(v[40:30], v[29:12], v[11], v[10]);
      check($sformatf("R11 R12 vector %0d", i), 1'b1, v[9], v[8], v[7:0]);
    end

    wr(3'd0, 0, 32'h0000_0000);   // ignored outside config mode
    send(11'h123, 18'h0, 1'b0, 1'b0);
    check("R2 write ignored in normal mode", 1'b1, 1'b1, 1'b0, 8'd0);

    cfg_mode_i = 1'b1;
    wr(3'd0, 0, 32'h0000_001D);   // drop F27
    cfg_mode_i = 1'b0;
    send(11'h050, 18'h0, 1'b0, 1'b0);
    check("R13 no match rejected", 1'b1, 1'b0, 1'b0, 8'd0);
    send(11'h011, 18'h0, 1'b0, 1'b0);
    check("R9 R12 still routed after F27 off", 1'b1, 1'b1, 1'b1, 8'd10);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule